// File: doc/BRIEF.md
# Configurable External Interrupt Channel

This block handles one external interrupt request line for an interrupt controller that works in fully nested mode. A 16-bit control word, written and read over a simple memory-mapped port, sets three things. The first is whether the line is treated as a rising-edge or an active-high level request. The second is whether the source is masked. The third is its 3-bit priority, where 0 is the highest and 7 the lowest. The pin passes through a two-stage synchronizer. The channel then tracks a pending flag. It drives a request toward the priority resolver whenever the flag is set and the source is not masked.

The channel drives its priority and a fixed vector type number (0x10) to the resolver. The processor clears the pending flag with a one-cycle acknowledge pulse. The line must stay high until that acknowledge arrives, in either trigger mode. If it falls before the acknowledge, the request is dropped. The mask bit has a second access path, so a global mask register can read and write the same storage without touching the rest of the control word. The channel has no cascade-mode behaviour.

Top module: `ext_irq_channel`

## Requirements
- R1: After reset the control word reads 0x000F (edge mode, masked, priority 7) and `irq_req` is low.
- R2: Bits 15 to 5 of the control word always read as zero. Whatever is written to them on `ctl_wdata` is discarded.
- R3: With bit 4 = 0 (edge mode), a low-to-high change on `irq_pin` sets the pending flag. `irq_req` rises after the third rising clock edge that follows the pin change. After an acknowledge, no new request appears while the pin stays high. The pin must go low and then high again.
- R4: With bit 4 = 1 (level mode), the pending flag follows a high pin. After an acknowledge with the pin still high, `irq_req` is low for one cycle and then returns.
- R5: If `irq_pin` falls before an acknowledge, the pending flag clears at the third clock edge after the fall, and the request is gone.
- R6: Bit 3 is the mask. While it is 1, `irq_req` stays low. The pending flag is kept, so clearing the mask exposes a request that is still held.
- R7: A write on `gmask_wr` sets bit 3 to `gmask_wdata`, and `gmask_rdata` always equals bit 3. If `ctl_wr` and `gmask_wr` are active in the same cycle, the mask comes from `gmask_wdata`.
- R8: `irq_prio` always equals bits 2 to 0 of the control word, and `irq_type` is the constant 0x10.
- R9: An acknowledge sampled at a clock edge clears the pending flag at that edge, so `irq_req` is low in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read value |
| gmask_wr | input | 1 | Write strobe from the global mask register |
| gmask_wdata | input | 1 | Mask value from the global mask register |
| gmask_rdata | output | 1 | Current mask bit for the global mask register |
| irq_pin | input | 1 | Asynchronous external request line |
| irq_ack | input | 1 | One-cycle acknowledge from the processor |
| irq_req | output | 1 | Request toward the priority resolver |
| irq_prio | output | 3 | Priority of this source, 0 highest |
| irq_type | output | 8 | Vector type number presented on service |

## Verification
The request path is tried with four pin patterns. A single rising pulse held through the acknowledge in edge mode shows the edge detector firing once and not again after the acknowledge. The same held-high pin in level mode shows the request coming back one cycle after the acknowledge, which is what separates the two trigger modes. A pin that falls before any acknowledge checks that the request is withdrawn. A pin raised while the source is masked, and then unmasked through the global path, shows that the pending flag is kept apart from the gate on the request. Register writes with the reserved bits set, and writes that collide on the two mask paths, cover the storage side of the channel.

// File: rtl/ext_irq_channel.sv
module ext_irq_channel #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned TYPE_W      = 8,
  parameter int unsigned TYPE_NUM    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              gmask_wr,
  input  logic              gmask_wdata,
  output logic              gmask_rdata,
  input  logic              irq_pin,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [PRIO_W-1:0] irq_prio,
  output logic [TYPE_W-1:0] irq_type
);

  localparam int unsigned MASK_BIT = PRIO_W;
  localparam int unsigned MODE_BIT = PRIO_W + 1;
  localparam int unsigned FIELD_W  = PRIO_W + 2;
  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((1 << FIELD_W) - 1);
  localparam logic [DATA_W-1:0] RST_VAL   = DATA_W'((1 << (PRIO_W + 1)) - 1);

  logic [DATA_W-1:0]      ctl_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   pin_s;
  logic                   rise;
  logic                   level_mode;

  assign pin_s      = sync_q[SYNC_STAGES-1];
  assign rise       = pin_s & ~prev_q;
  assign level_mode = ctl_q[MODE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= RST_VAL;
    end else begin
      if (ctl_wr)   ctl_q <= ctl_wdata & IMPL_MASK;
      if (gmask_wr) ctl_q[MASK_BIT] <= gmask_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], irq_pin};
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     pend_q <= 1'b0;
    else if (irq_ack)               pend_q <= 1'b0;
    else if (!pin_s)                pend_q <= 1'b0;
    else if (level_mode || rise)    pend_q <= 1'b1;
  end

  assign ctl_rdata   = ctl_q;
  assign gmask_rdata = ctl_q[MASK_BIT];
  assign irq_req     = pend_q & ~ctl_q[MASK_BIT];
  assign irq_prio    = ctl_q[PRIO_W-1:0];
  assign irq_type    = TYPE_W'(TYPE_NUM);

endmodule

// File: rtl/ext_irq_channel_checker.sv
module ext_irq_channel_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctl_rdata,
  input logic        gmask_rdata,
  input logic        irq_pin,
  input logic        irq_ack,
  input logic        irq_req,
  input logic [2:0]  irq_prio,
  input logic [7:0]  irq_type
);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[15:5] == 11'd0);

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[3] |-> !irq_req);

  p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_rdata == ctl_rdata[3]);

  p_prio_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_prio == ctl_rdata[2:0]) && (irq_type == 8'h10));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_req);

  p_pin_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(irq_pin, 3));

endmodule

bind ext_irq_channel ext_irq_channel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .gmask_rdata(gmask_rdata),
  .irq_pin(irq_pin), .irq_ack(irq_ack), .irq_req(irq_req),
  .irq_prio(irq_prio), .irq_type(irq_type)
);

// File: tb/tb_ext_irq_channel.sv
`timescale 1ns/1ps
module tb_ext_irq_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        gmask_wr = 1'b0;
  logic        gmask_wdata = 1'b0;
  logic        gmask_rdata;
  logic        irq_pin = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_prio;
  logic [7:0]  irq_type;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef enum logic [2:0] {F_REQ, F_RDATA, F_GMASK, F_PRIO, F_TYPE} field_e;
  typedef struct {
    field_e      fld;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  ext_irq_channel dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .gmask_wr(gmask_wr), .gmask_wdata(gmask_wdata),
    .gmask_rdata(gmask_rdata), .irq_pin(irq_pin), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_prio(irq_prio), .irq_type(irq_type)
  );

  function automatic logic [15:0] pick(field_e f);
    case (f)
      F_REQ:   return {15'd0, irq_req};
      F_RDATA: return ctl_rdata;
      F_GMASK: return {15'd0, gmask_rdata};
      F_PRIO:  return {13'd0, irq_prio};
      default: return {8'd0, irq_type};
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = pick(it.fld);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: field %s actual=%h expected=%h", it.tag, it.fld.name(), act, it.exp);
      end
    end
  end

  task automatic expect_item(field_e f, logic [15:0] v, string tag);
    item_t it;
    it.fld = f; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(logic [15:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    step(1);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wr_gmask(logic v);
    gmask_wr = 1'b1; gmask_wdata = v;
    step(1);
    gmask_wr = 1'b0;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state, R8 constants
    expect_item(F_RDATA, 16'h000F, "R1");
    expect_item(F_REQ,   16'd0,    "R1");
    expect_item(F_GMASK, 16'd1,    "R1");
    expect_item(F_PRIO,  16'd7,    "R8");
    expect_item(F_TYPE,  16'h0010, "R8");
    // R2 reserved bits discarded: edge mode, unmasked, prio 5
    wr_ctl(16'hFFE5);
    expect_item(F_RDATA, 16'h0005, "R2");
    expect_item(F_PRIO,  16'd5,    "R8");
    // R3 edge mode
    irq_pin = 1'b1;
    step(2);
    expect_item(F_REQ, 16'd0, "R3");
    step(1);
    expect_item(F_REQ, 16'd1, "R3");
    ack_pulse();
    expect_item(F_REQ, 16'd0, "R9");
    step(5);
    expect_item(F_REQ, 16'd0, "R3");
    irq_pin = 1'b0;
    step(4);
    irq_pin = 1'b1;
    step(3);
    expect_item(F_REQ, 16'd1, "R3");
    ack_pulse();
    irq_pin = 1'b0;
    step(4);
    // R5 withdrawal before acknowledge
    irq_pin = 1'b1;
    step(3);
    expect_item(F_REQ, 16'd1, "R5");
    irq_pin = 1'b0;
    step(2);
    expect_item(F_REQ, 16'd1, "R5");
    step(1);
    expect_item(F_REQ, 16'd0, "R5");
    step(4);
    expect_item(F_REQ, 16'd0, "R5");
    // R4 level mode, prio 5, unmasked
    wr_ctl(16'h0015);
    expect_item(F_RDATA, 16'h0015, "R4");
    irq_pin = 1'b1;
    step(3);
    expect_item(F_REQ, 16'd1, "R4");
    ack_pulse();
    expect_item(F_REQ, 16'd0, "R9");
    step(1);
    expect_item(F_REQ, 16'd1, "R4");
    irq_pin = 1'b0;
    step(3);
    expect_item(F_REQ, 16'd0, "R4");
    // R6 mask holds request back, pending retained
    wr_ctl(16'h000D);
    irq_pin = 1'b1;
    step(4);
    expect_item(F_REQ,   16'd0, "R6");
    expect_item(F_GMASK, 16'd1, "R7");
    wr_gmask(1'b0);
    expect_item(F_RDATA, 16'h0005, "R7");
    expect_item(F_GMASK, 16'd0,    "R7");
    expect_item(F_REQ,   16'd1,    "R6");
    wr_gmask(1'b1);
    expect_item(F_REQ, 16'd0, "R6");
    ack_pulse();
    irq_pin = 1'b0;
    step(4);
    // R7 collision: global path wins on the mask bit
    ctl_wr = 1'b1; ctl_wdata = 16'h0003;
    gmask_wr = 1'b1; gmask_wdata = 1'b1;
    step(1);
    ctl_wr = 1'b0; gmask_wr = 1'b0;
    expect_item(F_RDATA, 16'h000B, "R7");
    wr_gmask(1'b0);
    expect_item(F_RDATA, 16'h0003, "R7");
    expect_item(F_PRIO,  16'd3,    "R8");
    wr_ctl(16'h0002);
    expect_item(F_PRIO, 16'd2, "R8");
    expect_item(F_TYPE, 16'h0010, "R8");
    step(2);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule